// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End

This block is the fetch side of a small controller whose program store sits on its own bus, apart from the 8-bit data path. It holds the program counter and drives it as the program memory address. Every instruction cycle it captures one 12-bit instruction word, and each instruction fits in one word. The word captured in the previous cycle is presented to the execute stage at the same time, so fetching and executing overlap.

One instruction cycle lasts `CLKS_PER_CYCLE` oscillator clocks, four by default, which gives a 1 µs instruction cycle at 4 MHz. The block brings out its phase counter so that the execute stage can sequence its own work inside the cycle. All state changes at the clock edge that closes the last phase. Program memory must present the addressed word by that edge. A memory with a synchronous read and a one-clock latency meets this, because the address is held steady for the whole cycle.

Every instruction takes one cycle except a taken branch. When the execute stage requests a branch, the program counter loads the target and the word already fetched from the old path is discarded. The slot that follows is marked invalid, and the execute stage treats it as a no-op. A branch therefore costs two instruction cycles.

Top module: `fetch_pipe`

## Requirements
- R1: While `rst` is high and at the clock edge that releases it, `pmem_addr` equals `RESET_VEC`, `instr_valid` is 0 and `phase` is 0. The default `RESET_VEC` is `PMEM_DEPTH-1`.
- R2: `phase` steps once per clock through 0 to `CLKS_PER_CYCLE-1` and then returns to 0. `pmem_addr`, `instr`, `instr_addr` and `instr_valid` change only at the edge that ends phase `CLKS_PER_CYCLE-1`, called the cycle edge.
- R3: At a cycle edge with no taken branch, `instr` takes the `pmem_data` value present at that edge. At the same edge `instr_addr` takes the old `pmem_addr` and `instr_valid` becomes 1.
- R4: At a cycle edge with no taken branch, `pmem_addr` advances by one.
- R5: After address `PMEM_DEPTH-1`, the next sequential address is 0.
- R6: A branch is taken when `br_req` is 1 and `instr_valid` is 1 at a cycle edge. After a taken branch, `pmem_addr` equals the `br_target` value from that edge and `instr_valid` is 0 for the next instruction cycle.
- R7: One cycle edge after a taken branch, the target's word is presented with `instr_valid` 1 and `instr_addr` equal to the target. A branch therefore occupies two instruction cycles.
- R8: `br_req` has no effect at any edge other than a cycle edge. It also has no effect while `instr_valid` is 0, which covers a flushed slot and the first cycle after reset.
- R9: After reset, `instr_valid` stays 0 for exactly one instruction cycle. The first valid word is the word at `RESET_VEC`, and the following fetch address is 0 by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | PC_W | Program memory address, which is the program counter |
| pmem_data | input | 12 | Instruction word read from program memory |
| br_req | input | 1 | Branch request from the execute stage |
| br_target | input | PC_W | Branch target address |
| instr | output | 12 | Instruction word presented for execution |
| instr_addr | output | PC_W | Address that `instr` was fetched from |
| instr_valid | output | 1 | `instr` is a real instruction rather than a bubble |
| phase | output | PH_W | Phase within the current instruction cycle |

## Verification
The bound assertions check on every clock how the phase advances, that all fetch outputs are held steady inside a cycle, and the result of each cycle edge. That result is the sequential advance with wrap, the capture of the program word and its address, the flush that follows a taken branch, and a request ignored while the slot is a bubble. The bench scenarios show what a single clock cannot. These are the one-cycle delay before the first valid word after reset and the two-cycle branch from request to the target's word being presented. They also include a request seen only in middle phases having no effect, a wrap from the top address, and long random runs of branches mixed with straight-line fetch that are compared against a reference model.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INSTR_W = 12;
  typedef logic [INSTR_W-1:0] instr_t;
  localparam instr_t NOP_WORD = '0;
endpackage

// File: rtl/fetch_phase.sv
module fetch_phase #(
  parameter int unsigned CLKS_PER_CYCLE = 4,
  localparam int unsigned PH_W = (CLKS_PER_CYCLE > 1) ? $clog2(CLKS_PER_CYCLE) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            cyc_end
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_CYCLE - 1);

  assign cyc_end = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (cyc_end) phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
  parameter int unsigned PMEM_DEPTH = 1024,
  parameter int unsigned RESET_VEC  = PMEM_DEPTH - 1,
  localparam int unsigned PC_W = $clog2(PMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            load,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] PC_TOP = PC_W'(PMEM_DEPTH - 1);
  localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_VEC);

  logic [PC_W-1:0] pc_seq;
  assign pc_seq = (pc == PC_TOP) ? '0 : pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       pc <= PC_RST;
    else if (load) pc <= target;
    else if (step) pc <= pc_seq;
  end
endmodule

// File: rtl/fetch_slot.sv
module fetch_slot #(
  parameter int unsigned PC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             flush,
  input  fetch_pkg::instr_t word_in,
  input  logic [PC_W-1:0]  addr_in,
  output fetch_pkg::instr_t instr,
  output logic [PC_W-1:0]  instr_addr,
  output logic             valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr      <= fetch_pkg::NOP_WORD;
      instr_addr <= '0;
      valid      <= 1'b0;
    end else if (flush) begin
      instr      <= fetch_pkg::NOP_WORD;
      valid      <= 1'b0;
    end else if (advance) begin
      instr      <= word_in;
      instr_addr <= addr_in;
      valid      <= 1'b1;
    end
  end
endmodule

// File: rtl/fetch_pipe.sv
module fetch_pipe #(
  parameter int unsigned PMEM_DEPTH     = 1024,
  parameter int unsigned CLKS_PER_CYCLE = 4,
  parameter int unsigned RESET_VEC      = PMEM_DEPTH - 1,
  localparam int unsigned PC_W = $clog2(PMEM_DEPTH),
  localparam int unsigned PH_W = (CLKS_PER_CYCLE > 1) ? $clog2(CLKS_PER_CYCLE) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [PC_W-1:0]               pmem_addr,
  input  logic [fetch_pkg::INSTR_W-1:0] pmem_data,
  input  logic                          br_req,
  input  logic [PC_W-1:0]               br_target,
  output logic [fetch_pkg::INSTR_W-1:0] instr,
  output logic [PC_W-1:0]               instr_addr,
  output logic                          instr_valid,
  output logic [PH_W-1:0]               phase
);
  logic cyc_end;
  logic take;
  logic seq;

  assign take = cyc_end & br_req & instr_valid;
  assign seq  = cyc_end & ~take;

  fetch_phase #(.CLKS_PER_CYCLE(CLKS_PER_CYCLE)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .cyc_end(cyc_end)
  );

  fetch_pc #(.PMEM_DEPTH(PMEM_DEPTH), .RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst(rst), .step(seq), .load(take),
    .target(br_target), .pc(pmem_addr)
  );

  fetch_slot #(.PC_W(PC_W)) u_slot (
    .clk(clk), .rst(rst), .advance(seq), .flush(take),
    .word_in(pmem_data), .addr_in(pmem_addr),
    .instr(instr), .instr_addr(instr_addr), .valid(instr_valid)
  );
endmodule

// File: rtl/fetch_pipe_chk.sv
module fetch_pipe_chk #(
  parameter int unsigned PMEM_DEPTH     = 1024,
  parameter int unsigned CLKS_PER_CYCLE = 4,
  localparam int unsigned PC_W = $clog2(PMEM_DEPTH),
  localparam int unsigned PH_W = (CLKS_PER_CYCLE > 1) ? $clog2(CLKS_PER_CYCLE) : 1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [PC_W-1:0]               pmem_addr,
  input logic [fetch_pkg::INSTR_W-1:0] pmem_data,
  input logic                          br_req,
  input logic [PC_W-1:0]               br_target,
  input logic [fetch_pkg::INSTR_W-1:0] instr,
  input logic [PC_W-1:0]               instr_addr,
  input logic                          instr_valid,
  input logic [PH_W-1:0]               phase
);
  localparam logic [PH_W-1:0] LASTPH = PH_W'(CLKS_PER_CYCLE - 1);

  function automatic logic [PC_W-1:0] wrap_inc(input logic [PC_W-1:0] a);
    return (a == PC_W'(PMEM_DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  logic edge_now;
  assign edge_now = (phase == LASTPH);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    live |-> (phase == (($past(phase) == LASTPH) ? '0 : $past(phase) + 1'b1)));

  p_hold_mid_r2: assert property (@(posedge clk) disable iff (rst)
    (live && !edge_now) |=> ($stable(pmem_addr) && $stable(instr_valid)
                              && $stable(instr) && $stable(instr_addr)));

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (live && edge_now && !(br_req && instr_valid)) |=>
      (instr_valid && instr == $past(pmem_data) && instr_addr == $past(pmem_addr)));

  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (live && edge_now && !(br_req && instr_valid)) |=>
      (pmem_addr == wrap_inc($past(pmem_addr))));

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (live && edge_now && br_req && instr_valid) |=>
      (!instr_valid && pmem_addr == $past(br_target)));

  p_bubble_ignores_r8: assert property (@(posedge clk) disable iff (rst)
    (live && edge_now && br_req && !instr_valid) |=> instr_valid);
endmodule

bind fetch_pipe fetch_pipe_chk #(
  .PMEM_DEPTH(PMEM_DEPTH), .CLKS_PER_CYCLE(CLKS_PER_CYCLE)
) u_chk (.*);

// File: tb/tb_fetch_pipe.sv
module tb_fetch_pipe;
  localparam int unsigned DEPTH = 1024;
  localparam int unsigned NCLK  = 4;
  localparam int unsigned PC_W  = 10;
  localparam int unsigned PH_W  = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pmem_addr;
  logic [11:0]     pmem_data;
  logic            br_req = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [11:0]     instr;
  logic [PC_W-1:0] instr_addr;
  logic            instr_valid;
  logic [PH_W-1:0] phase;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [11:0] word_of(input logic [PC_W-1:0] a);
    return 12'((a * 37) ^ 12'h5A3 ^ (a >> 3));
  endfunction

  assign pmem_data = word_of(pmem_addr);

  fetch_pipe #(.PMEM_DEPTH(DEPTH), .CLKS_PER_CYCLE(NCLK)) dut (
    .clk(clk), .rst(rst), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .br_req(br_req), .br_target(br_target), .instr(instr),
    .instr_addr(instr_addr), .instr_valid(instr_valid), .phase(phase)
  );

  // reference model
  int unsigned     m_ph;
  logic [PC_W-1:0] m_pc;
  logic [11:0]     m_instr;
  logic [PC_W-1:0] m_iaddr;
  logic            m_valid;
  string           m_tag;

  function automatic void model_step(input logic b, input logic [PC_W-1:0] t);
    bit last = (m_ph == NCLK - 1);
    m_ph = last ? 0 : m_ph + 1;
    m_tag = "R2";
    if (last) begin
      if (b && m_valid) begin
        m_pc = t; m_valid = 1'b0; m_tag = "R6";
      end else begin
        m_tag = b ? "R8" : (m_pc == PC_W'(DEPTH - 1)) ? "R5" : "R4";
        m_instr = word_of(m_pc); m_iaddr = m_pc; m_valid = 1'b1;
        m_pc = (m_pc == PC_W'(DEPTH - 1)) ? '0 : m_pc + 1'b1;
      end
    end
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit ok = (phase == PH_W'(m_ph)) && (pmem_addr == m_pc) && (instr_valid == m_valid)
             && (!m_valid || (instr == m_instr && instr_addr == m_iaddr));
    vectors++;
    if (!ok) begin
      errors++;
      if (phase != PH_W'(m_ph))
        $display("FAIL R2 phase actual=%0d expected=%0d", phase, m_ph);
      if (pmem_addr != m_pc)
        $display("FAIL %s pmem_addr actual=%0d expected=%0d", m_tag, pmem_addr, m_pc);
      if (instr_valid != m_valid)
        $display("FAIL %s instr_valid actual=%0d expected=%0d", m_tag, instr_valid, m_valid);
      if (m_valid && instr != m_instr)
        $display("FAIL R3 instr actual=%0h expected=%0h", instr, m_instr);
      if (m_valid && instr_addr != m_iaddr)
        $display("FAIL R3 instr_addr actual=%0d expected=%0d", instr_addr, m_iaddr);
    end
  endtask

  task automatic tick(input logic b, input logic [PC_W-1:0] t);
    br_req = b; br_target = t;
    @(posedge clk);
    model_step(b, t);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_to_last();
    while (m_ph != NCLK - 1) tick(1'b0, '0);
  endtask

  initial begin
    m_ph = 0; m_pc = PC_W'(DEPTH - 1); m_instr = '0; m_iaddr = '0;
    m_valid = 1'b0; m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", pmem_addr == PC_W'(DEPTH - 1), pmem_addr, DEPTH - 1);
    check("R1", instr_valid == 1'b0, instr_valid, 0);
    check("R1", phase == '0, phase, 0);
    rst = 1'b0;

    // R9 first cycle is a bubble
    repeat (3) tick(1'b0, '0);
    check("R9", instr_valid == 1'b0, instr_valid, 0);
    tick(1'b0, '0);
    check("R9", instr_valid == 1'b1, instr_valid, 1);
    check("R9", instr == word_of(PC_W'(DEPTH - 1)), instr, word_of(PC_W'(DEPTH - 1)));
    check("R5", pmem_addr == '0, pmem_addr, 0);

    // R8 request only in middle phases is ignored
    repeat (3) tick(1'b1, 10'd5);
    tick(1'b0, '0);
    check("R8", pmem_addr == 10'd1, pmem_addr, 1);
    check("R8", instr_valid == 1'b1, instr_valid, 1);

    // R6 taken branch
    run_to_last();
    tick(1'b1, 10'd700);
    check("R6", instr_valid == 1'b0, instr_valid, 0);
    check("R6", pmem_addr == 10'd700, pmem_addr, 700);

    // R8 request during the bubble is ignored; R7 target word arrives
    run_to_last();
    tick(1'b1, 10'd5);
    check("R7", instr_valid == 1'b1, instr_valid, 1);
    check("R7", instr_addr == 10'd700, instr_addr, 700);
    check("R7", instr == word_of(10'd700), instr, word_of(10'd700));
    check("R8", pmem_addr == 10'd701, pmem_addr, 701);

    // R5 branch near the top, then straight line across the wrap
    run_to_last();
    tick(1'b1, 10'd1022);
    repeat (3 * NCLK) tick(1'b0, '0);
    check("R5", pmem_addr == 10'd1, pmem_addr, 1);

    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic b = ($urandom % 6) == 0;
      logic [PC_W-1:0] t = (($urandom % 4) == 0) ? PC_W'(DEPTH - 1 - ($urandom % 2))
                                                  : PC_W'($urandom);
      tick(b, t);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule